// File: doc/BRIEF.md
# NOR Flash Command Interpreter

This block models the command state machine of a byte-wide parallel NOR flash. The bus has chip-enable, write-enable and output-enable strobes, all active low. They are sampled on the block clock. A write is an active chip-enable with a low-to-high pulse on write-enable. The address is captured when write-enable falls, and the data byte is taken when it rises. Coded write sequences start three embedded operations: a byte program, a whole-array erase, and an erase of a queued set of sectors.

The storage is a small register array, split into `SECT_N` equal sectors. The sector number is the upper address bits. While an embedded operation runs, or while a program failure is pending, a read returns a status byte instead of array data. The erase-accept window, the program time and the erase time are all parameters counted in clock cycles. Simulation can therefore use short values.

Sector erase does not start at once. It first opens a retriggerable accept window, and further sector-erase writes inside that window add sectors to the queue. Either kind of erase pre-clears every byte of a selected sector to 0x00 before setting it to 0xFF. The sectors are processed in ascending order.

Top module: `nfc_top`

## Requirements
- R1: After reset the block is in read mode, every array byte reads 0xFF, and no operation is pending.
- R2: With ce_n and oe_n both low, dout_oe is 1. In read mode dout then carries the array byte at addr. dout_oe is 0 whenever ce_n or oe_n is high.
- R3: The unlock pair is the low address bits of 0x555 with data 0xAA, then the low address bits of 0x2AA with data 0x55. The next write carries the command code at any address. Any write that breaks the pair returns the block to read mode, and the array is left unchanged.
- R4: Command 0xA0 arms a program. The next write's address and data start it, and the array is updated PROG_CYC cycles after that write-enable rising edge.
- R5: Writes that arrive while a program is busy are ignored.
- R6: While a program is busy, a read returns a status byte. Bit 7 is the complement of bit 7 of the data being written. All other bits are 0.
- R7: A program stores the old byte ANDed with the new byte, so no bit goes from 0 to 1.
- R8: If the new byte has a 1 where the old byte has a 0, the block stays in a failed state once the program ends. In that state the status byte has bit 5 = 1, bit 7 = the complement of the data's bit 7, and all other bits 0. Only a write of 0xF0 returns it to read mode.
- R9: Setup 0x80, then a second unlock pair, then 0x30 opens the sector-erase window. The window lasts WIN_CYC cycles and restarts on every write-enable edge. While it is open the status byte is 0x00.
- R10: Each further 0x30 write inside the window queues the sector of its address. The queued sectors may come in any order.
- R11: When the window expires, each queued sector is set to 0x00 and then to 0xFF, in ascending sector order. Unqueued sectors are untouched. While this runs the status byte is 0x08 (bit 3 set, bit 7 clear), and the block returns to read mode at the end.
- R12: In the window, any data other than 0x30 or 0xB0 drops the queue and returns the block to read mode, with no erase.
- R13: During an erase, 0xB0 suspends it and reads return array data. While suspended, only 0x30 resumes the erase and all other writes are ignored. While the erase runs, only 0xB0 is accepted.
- R14: Command 0x10 in place of 0x30 erases every sector at once, with no window, and shows the same 0x08 status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| dout_oe | output | 1 | Read data valid on dout |

## Verification
Byte programs are tried on erased bytes, on already-programmed bytes with a subset pattern, and on bytes with a pattern that sets cleared bits. These cases separate a plain overwrite from the AND rule and from the failure path. Unlock sequences are sent both intact and broken, which separates the command decoder from stray data writes. Sector erases are run with two queued sectors, with a late second write that only succeeds if the window restarts, with an abort inside the window, and with a suspend/resume in the middle. A final whole-array erase confirms that every sector is reached.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [3:0] {
        ST_READ, ST_UL1, ST_UL2, ST_PGM_ARM, ST_SETUP, ST_UL3, ST_UL4,
        ST_PGM_BUSY, ST_PGM_FAIL, ST_WIN, ST_ERASE, ST_SUSP
    } nfc_state_e;

    typedef enum logic [1:0] {PH_ZERO, PH_WAIT, PH_FILL} nfc_phase_e;

    localparam logic [7:0] CODE_KEY1   = 8'hAA;
    localparam logic [7:0] CODE_KEY2   = 8'h55;
    localparam logic [7:0] CODE_SETUP  = 8'h80;
    localparam logic [7:0] CODE_CHIP   = 8'h10;
    localparam logic [7:0] CODE_SECT   = 8'h30;
    localparam logic [7:0] CODE_PGM    = 8'hA0;
    localparam logic [7:0] CODE_SUSP   = 8'hB0;
    localparam logic [7:0] CODE_RESUME = 8'h30;
    localparam logic [7:0] CODE_CLEAR  = 8'hF0;
endpackage

// File: rtl/nfc_edge.sv
module nfc_edge #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              we_fall,
    output logic              we_rise,
    output logic [ADDR_W-1:0] addr_lat
);
    logic we_q;

    assign we_fall = !ce_n &&  we_q && !we_n;
    assign we_rise = !ce_n && !we_q &&  we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            addr_lat <= '0;
        end else begin
            we_q <= we_n;
            if (we_fall) addr_lat <= addr;
        end
    end
endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [7:0]        rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [7:0]        rd_data_b
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [7:0] mem [DEPTH];

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/nfc_status.sv
module nfc_status
    import nfc_pkg::*;
(
    input  nfc_state_e state,
    input  logic       pgm_msb,
    output logic       busy,
    output logic [7:0] stat
);
    always_comb begin
        busy = 1'b1;
        stat = 8'h00;
        unique case (state)
            ST_PGM_BUSY: stat = {~pgm_msb, 7'b0};
            ST_PGM_FAIL: stat = {~pgm_msb, 1'b0, 1'b1, 5'b0};
            ST_WIN:      stat = 8'h00;
            ST_ERASE:    stat = 8'h08;
            default:     busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/nfc_top.sv
module nfc_top
    import nfc_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          SECT_N    = 8,
    parameter logic [10:0] KEY1_ADDR = 11'h555,
    parameter logic [10:0] KEY2_ADDR = 11'h2AA,
    parameter int          WIN_CYC   = 2000,
    parameter int          PROG_CYC  = 300,
    parameter int          ERASE_CYC = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_oe
);
    localparam int SECT_W  = $clog2(SECT_N);
    localparam int OFF_W   = ADDR_W - SECT_W;
    localparam int TMR_MX1 = (WIN_CYC > PROG_CYC) ? WIN_CYC : PROG_CYC;
    localparam int TMR_MAX = (TMR_MX1 > ERASE_CYC) ? TMR_MX1 : ERASE_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [ADDR_W-1:0] K1A = KEY1_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] K2A = KEY2_ADDR[ADDR_W-1:0];

    typedef struct packed {
        nfc_state_e        state;
        nfc_phase_e        phase;
        logic [SECT_N-1:0] sel;
        logic [SECT_W-1:0] sect;
        logic [OFF_W-1:0]  off;
        logic [TMR_W-1:0]  tmr;
        logic [ADDR_W-1:0] pa;
        logic [7:0]        pd;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              we_fall, we_rise;
    logic [ADDR_W-1:0] addr_lat;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic [7:0]        mem_wd;
    logic [7:0]        rd_a, rd_b;
    logic              busy;
    logic [7:0]        stat;
    logic              adv;
    logic [SECT_N-1:0] lat_bit;

    nfc_edge #(.ADDR_W(ADDR_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .we_fall(we_fall), .we_rise(we_rise), .addr_lat(addr_lat)
    );

    nfc_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(mem_we), .wr_addr(mem_wa), .wr_data(mem_wd),
        .rd_addr_a(addr), .rd_data_a(rd_a),
        .rd_addr_b(regs_q.pa), .rd_data_b(rd_b)
    );

    nfc_status u_status (
        .state(regs_q.state), .pgm_msb(regs_q.pd[7]), .busy(busy), .stat(stat)
    );

    assign lat_bit = SECT_N'(1) << addr_lat[ADDR_W-1 -: SECT_W];
    assign dout_oe = !ce_n && !oe_n;
    assign dout    = busy ? stat : rd_a;

    always_comb begin
        regs_d = regs_q;
        mem_we = 1'b0;
        mem_wa = '0;
        mem_wd = '0;
        adv    = 1'b0;
        unique case (regs_q.state)
            ST_READ: if (we_rise && addr_lat == K1A && din == CODE_KEY1)
                         regs_d.state = ST_UL1;
            ST_UL1: if (we_rise)
                        regs_d.state = (addr_lat == K2A && din == CODE_KEY2) ? ST_UL2 : ST_READ;
            ST_UL2: if (we_rise) begin
                        if (din == CODE_PGM)        regs_d.state = ST_PGM_ARM;
                        else if (din == CODE_SETUP) regs_d.state = ST_SETUP;
                        else                        regs_d.state = ST_READ;
                    end
            ST_PGM_ARM: if (we_rise) begin
                        regs_d.pa    = addr_lat;
                        regs_d.pd    = din;
                        regs_d.tmr   = TMR_W'(PROG_CYC - 1);
                        regs_d.state = ST_PGM_BUSY;
                    end
            ST_PGM_BUSY: begin
                if (regs_q.tmr == '0) begin
                    mem_we = 1'b1;
                    mem_wa = regs_q.pa;
                    mem_wd = rd_b & regs_q.pd;
                    regs_d.state = ((~rd_b & regs_q.pd) != 8'h00) ? ST_PGM_FAIL : ST_READ;
                end else begin
                    regs_d.tmr = regs_q.tmr - 1'b1;
                end
            end
            ST_PGM_FAIL: if (we_rise && din == CODE_CLEAR) regs_d.state = ST_READ;
            ST_SETUP: if (we_rise)
                        regs_d.state = (addr_lat == K1A && din == CODE_KEY1) ? ST_UL3 : ST_READ;
            ST_UL3: if (we_rise)
                        regs_d.state = (addr_lat == K2A && din == CODE_KEY2) ? ST_UL4 : ST_READ;
            ST_UL4: if (we_rise) begin
                        regs_d.sect  = '0;
                        regs_d.off   = '0;
                        regs_d.phase = PH_ZERO;
                        if (din == CODE_CHIP) begin
                            regs_d.sel   = '1;
                            regs_d.state = ST_ERASE;
                        end else if (din == CODE_SECT) begin
                            regs_d.sel   = lat_bit;
                            regs_d.tmr   = TMR_W'(WIN_CYC - 1);
                            regs_d.state = ST_WIN;
                        end else begin
                            regs_d.state = ST_READ;
                        end
                    end
            ST_WIN: begin
                if (we_fall) begin
                    regs_d.tmr = TMR_W'(WIN_CYC - 1);
                end else if (we_rise) begin
                    regs_d.tmr = TMR_W'(WIN_CYC - 1);
                    if (din == CODE_SECT) begin
                        regs_d.sel = regs_q.sel | lat_bit;
                    end else if (din != CODE_SUSP) begin
                        regs_d.sel   = '0;
                        regs_d.state = ST_READ;
                    end
                end else if (regs_q.tmr == '0) begin
                    regs_d.state = ST_ERASE;
                end else begin
                    regs_d.tmr = regs_q.tmr - 1'b1;
                end
            end
            ST_ERASE: begin
                if (we_rise && din == CODE_SUSP) begin
                    regs_d.state = ST_SUSP;
                end else if (!regs_q.sel[regs_q.sect]) begin
                    adv = 1'b1;
                end else begin
                    unique case (regs_q.phase)
                        PH_ZERO: begin
                            mem_we = 1'b1;
                            mem_wa = {regs_q.sect, regs_q.off};
                            mem_wd = 8'h00;
                            regs_d.off = regs_q.off + 1'b1;
                            if (regs_q.off == '1) begin
                                regs_d.phase = PH_WAIT;
                                regs_d.tmr   = TMR_W'(ERASE_CYC - 1);
                            end
                        end
                        PH_WAIT: begin
                            if (regs_q.tmr == '0) regs_d.phase = PH_FILL;
                            else                  regs_d.tmr   = regs_q.tmr - 1'b1;
                        end
                        default: begin
                            mem_we = 1'b1;
                            mem_wa = {regs_q.sect, regs_q.off};
                            mem_wd = 8'hFF;
                            regs_d.off = regs_q.off + 1'b1;
                            if (regs_q.off == '1) begin
                                regs_d.phase = PH_ZERO;
                                adv = 1'b1;
                            end
                        end
                    endcase
                end
            end
            ST_SUSP: if (we_rise && din == CODE_RESUME) regs_d.state = ST_ERASE;
            default: regs_d.state = ST_READ;
        endcase
        if (adv) begin
            if (regs_q.sect == SECT_W'(SECT_N - 1)) begin
                regs_d.sel   = '0;
                regs_d.sect  = '0;
                regs_d.state = ST_READ;
            end else begin
                regs_d.sect = regs_q.sect + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.state <= ST_READ;
            regs_q.phase <= PH_ZERO;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/nfc_checker.sv
module nfc_checker
    import nfc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SECT_N  = 8,
    parameter int TMR_W   = 12,
    parameter int WIN_CYC = 2000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              dout_oe,
    input logic [7:0]        din,
    input logic              we_rise,
    input nfc_state_e        state,
    input logic [SECT_N-1:0] sel,
    input logic [TMR_W-1:0]  tmr,
    input logic [ADDR_W-1:0] pa,
    input logic [7:0]        pd,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_wa
);
    localparam int SECT_W = $clog2(SECT_N);

    a_r2_no_drive_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dout_oe);

    a_r1_read_mode_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |-> !mem_we);

    a_r5_prog_target_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM_BUSY && $past(state) == ST_PGM_BUSY) |-> ($stable(pa) && $stable(pd)));

    a_r9_window_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIN) |-> (tmr < TMR_W'(WIN_CYC)));

    a_r11_erase_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state == ST_ERASE) |-> sel[mem_wa[ADDR_W-1 -: SECT_W]]);

    a_r12_window_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIN && we_rise && din != CODE_SECT && din != CODE_SUSP)
        |=> (state == ST_READ && sel == '0));
endmodule

bind nfc_top nfc_checker #(
    .ADDR_W(ADDR_W), .SECT_N(SECT_N), .TMR_W(TMR_W), .WIN_CYC(WIN_CYC)
) u_nfc_checker (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .dout_oe(dout_oe), .din(din),
    .we_rise(we_rise), .state(regs_q.state), .sel(regs_q.sel), .tmr(regs_q.tmr),
    .pa(regs_q.pa), .pd(regs_q.pd), .mem_we(mem_we), .mem_wa(mem_wa)
);

// File: tb/nfc_top_bench.sv
module nfc_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [7:0] addr = '0, din = '0;
    logic [7:0] dout;
    logic       dout_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       ev_smp;

    always #2 clk = ~clk;

    nfc_top #(.ADDR_W(8), .SECT_N(8), .WIN_CYC(20), .PROG_CYC(16), .ERASE_CYC(8)) u_nfc_top (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per sample event
    initial forever begin
        @(ev_smp);
        chk({tag_q[0], " oe"}, {7'b0, dout_oe}, 8'h01);
        chk(tag_q.pop_front(), dout, exp_q.pop_front());
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        -> ev_smp;
        @(negedge clk); oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic prog(input logic [7:0] a, input logic [7:0] d);
        wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'hA0); wr(a, d);
    endtask

    task automatic erase_prefix();
        wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'h80);
        wr(8'h55, 8'hAA); wr(8'hAA, 8'h55);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3); rst_n = 1'b1; idle(2);
        // R1 reset: erased array, read mode
        rd(8'h00, 8'hFF, "R1 reset byte 0x00");
        rd(8'hFF, 8'hFF, "R1 reset byte 0xFF");
        // R2 output enable gating
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); chk("R2 oe_n high", {7'b0, dout_oe}, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); chk("R2 ce_n high", {7'b0, dout_oe}, 8'h00);
        oe_n = 1'b1;
        // R4 program an erased byte
        prog(8'h10, 8'h5A); idle(25);
        rd(8'h10, 8'h5A, "R4 program result");
        // R7/R8 program sets cleared bits: AND stored, fail status
        prog(8'h10, 8'hF0); idle(25);
        rd(8'h10, 8'h20, "R8 fail status");
        wr(8'h00, 8'h12);
        rd(8'h10, 8'h20, "R8 fail held");
        wr(8'h00, 8'hF0);
        rd(8'h10, 8'h50, "R7 AND result");
        // R6 status while busy
        prog(8'h20, 8'h0F);
        rd(8'h20, 8'h80, "R6 busy status");
        idle(25);
        rd(8'h20, 8'h0F, "R6 final data");
        // R3 broken unlock
        wr(8'h55, 8'hAA); wr(8'hAA, 8'h11); wr(8'h55, 8'hA0); wr(8'h30, 8'h00);
        idle(25);
        rd(8'h30, 8'hFF, "R3 broken unlock");
        // R5 write during program ignored
        prog(8'h40, 8'h33);
        wr(8'h40, 8'h00);
        idle(25);
        rd(8'h40, 8'h33, "R5 write ignored");
        rd(8'h41, 8'hFF, "R5 neighbour");
        // R9/R10/R11 sector erase of sectors 1 and 2
        erase_prefix(); wr(8'h25, 8'h30);
        idle(10);
        wr(8'h45, 8'h30);
        idle(10);
        rd(8'h00, 8'h00, "R9 window status after restart");
        idle(30);
        rd(8'h00, 8'h08, "R11 erase status");
        idle(300);
        rd(8'h20, 8'hFF, "R11 sector1 erased");
        rd(8'h40, 8'hFF, "R10 queued sector2 erased");
        rd(8'h10, 8'h50, "R11 sector0 untouched");
        // R12 abort in window
        prog(8'h60, 8'h12); idle(25);
        erase_prefix(); wr(8'h60, 8'h30);
        wr(8'h00, 8'h55);
        rd(8'h00, 8'hFF, "R12 read mode after abort");
        idle(60);
        rd(8'h60, 8'h12, "R12 no erase");
        // R13 suspend / resume
        erase_prefix(); wr(8'h60, 8'h30);
        idle(25);
        wr(8'h00, 8'hB0);
        rd(8'h10, 8'h50, "R13 suspended read");
        wr(8'h00, 8'hA0);
        rd(8'h10, 8'h50, "R13 write ignored in suspend");
        wr(8'h00, 8'h30);
        idle(200);
        rd(8'h60, 8'hFF, "R13 resumed erase done");
        // R14 chip erase
        prog(8'hE5, 8'h77); idle(25);
        rd(8'hE5, 8'h77, "R14 before chip erase");
        erase_prefix(); wr(8'h55, 8'h10);
        rd(8'h00, 8'h08, "R14 chip erase status");
        idle(800);
        rd(8'hE5, 8'hFF, "R14 last sector erased");
        rd(8'h10, 8'hFF, "R14 first sector erased");
        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule